// File: doc/BRIEF.md
# Single-Channel Two-Cycle DMA Engine

This block is one DMA channel. It copies a block of bytes from a source region to a destination region. Each transfer unit takes two bus cycles: a read at the source address, then a write at the destination address. The data read is held in a data latch and driven during the write. Software sets up the channel through a small register port. It writes 24-bit source and destination start addresses and a 24-bit byte count, then picks the unit width (8 or 16 bits), a direction for each side, and whether the terminal-count pin is active. Finally it sets the enable bit.

A rising edge on the request input, seen while the channel is enabled, marks a request pending. From then on, read/write pairs run back to back until the count is used up. At that point the block emits a one-clock terminal-count pulse, sets a sticky interrupt flag, and clears both the enable bit and the pending request. Software can abort a transfer by writing 0 to the enable bit, or by pulling the stop pin low while the pin is active. An abort stops the channel at once and does not raise the interrupt.

The block keeps the values software wrote to the address and count registers in separate shadow copies. Setting enable again therefore repeats the same transfer without reprogramming.

Top module: `dma_engine`

## Requirements
- R1: Register offsets are 0 source address, 1 destination address, 2 byte count (all 24 bits), 3 mode, 4 control/status. While the channel is disabled, a write to offsets 0 to 2 reads back unchanged at the same offset. Mode bits are: bit 0 selects 16-bit units, bits 2:1 set the source direction, bits 4:3 set the destination direction, bit 5 makes the stop/terminal-count pin active. Control/status bits are: bit 0 enable (read/write), bit 1 request pending (read only), bit 2 interrupt flag (reads 1 when set; writing 1 clears it).
- R2: Each unit is one read cycle (bus_req=1, bus_we=0, address from the source register) followed by one write cycle (bus_we=1, address from the destination register). The write drives the 16-bit word captured when the read completed. A run of N bytes makes ceil(N/2) units in 16-bit mode and N units in byte mode.
- R3: Direction code 0 moves forward, code 1 moves backward, and codes 2 and 3 hold the address fixed. After each completed cycle the address steps by 1 for byte units or 2 for 16-bit units, modulo 2^24.
- R4: When a read completes, the count drops by the unit size and saturates at 0. It reads 0 after the transfer finishes, including an odd count with 16-bit units.
- R5: A write that completes with the count at 0 ends the transfer. It clears enable and pending, sets the interrupt flag, and gives one clock of tc_out high when the pin is active.
- R6: Writing 0 to the enable bit during a transfer drops bus_req on the next cycle. No further bus cycles follow, and neither the interrupt flag nor tc_out is raised.
- R7: Driving tc_stop_n low while the pin is active aborts the transfer the same way as R6. When the pin is inactive, tc_stop_n is ignored and the transfer completes.
- R8: Setting enable from 0 to 1 reloads the working registers from the values software last wrote. A second run then repeats the same bus addresses and data.
- R9: A request is taken only on a rising edge of dreq while enabled. A dreq level that is already high when enable is set, or an edge while disabled, starts nothing.
- R10: A bus cycle completes only on a clock where bus_rdy is high. Until then the bus address, direction and data stay unchanged.
- R11: The interrupt flag stays set until software writes 1 to control bit 2.
- R12: With the pin inactive, tc_out stays low at terminal count, and the interrupt flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 24 | Register write data |
| reg_rdata | output | 24 | Register read data (combinational on reg_addr) |
| dreq | input | 1 | Transfer request, rising-edge sensed |
| tc_stop_n | input | 1 | Active-low forced stop when the pin is active |
| tc_out | output | 1 | Terminal-count pulse |
| irq | output | 1 | Sticky interrupt flag |
| bus_req | output | 1 | Bus cycle in progress |
| bus_we | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_wide | output | 1 | 1 = 16-bit unit, 0 = byte |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data from the data latch |
| bus_rdata | input | 16 | Read data |
| bus_rdy | input | 1 | Cycle completes on this clock |

## Verification
The embedded properties check the following on every cycle:
- a stalled bus cycle holds its address and direction;
- a completed read is always followed by a write;
- the count never grows on a read;
- an abort leaves the bus idle with the channel disabled and no new interrupt;
- the terminal-count pulse lasts one clock;
- the interrupt flag stays set until it is cleared.

Only the bench scenarios show the full picture:
- the exact address sequences for every direction and width mix;
- the data carried from each read into the following write;
- the number of units for odd counts;
- the ignored-request cases;
- the identical replay after re-enabling.

// File: rtl/dma_engine.sv
module dma_engine #(
  parameter int AW = 24,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          dreq,
  input  logic          tc_stop_n,
  output logic          tc_out,
  output logic          irq,
  output logic          bus_req,
  output logic          bus_we,
  output logic          bus_wide,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic [DW-1:0] bus_rdata,
  input  logic          bus_rdy
);

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} state_t;
  localparam int MW = 6;

  state_t state;
  logic [AW-1:0] sh_src, sh_dst, sh_cnt, src, dst, cnt;
  logic [MW-1:0] mode;
  logic          en, pend, irq_q, tc_q, dreq_q;
  logic [DW-1:0] dlatch;

  wire          wide   = mode[0];
  wire [1:0]    sdir   = mode[2:1];
  wire [1:0]    ddir   = mode[4:3];
  wire          pin_en = mode[5];
  wire [AW-1:0] step   = wide ? AW'(2) : AW'(1);

  wire ctrl_wr = reg_we && (reg_addr == 3'd4);
  wire en_set  = ctrl_wr && reg_wdata[0] && !en;
  wire stop    = en && ((ctrl_wr && !reg_wdata[0]) || (pin_en && !tc_stop_n));
  wire rd_done = (state == S_RD) && bus_rdy && !stop;
  wire wr_done = (state == S_WR) && bus_rdy && !stop;
  wire finish  = wr_done && (cnt == '0);
  wire [AW-1:0] cnt_nx = (cnt > step) ? cnt - step : '0;

  function automatic logic [AW-1:0] adv(input logic [AW-1:0] a, input logic [1:0] d,
                                        input logic [AW-1:0] s);
    case (d)
      2'd0:    return a + s;
      2'd1:    return a - s;
      default: return a;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_src <= '0; sh_dst <= '0; sh_cnt <= '0; mode <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: sh_src <= reg_wdata;
        3'd1: sh_dst <= reg_wdata;
        3'd2: sh_cnt <= reg_wdata;
        3'd3: mode   <= reg_wdata[MW-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src <= '0; dst <= '0; cnt <= '0;
    end else if (en_set) begin
      src <= sh_src; dst <= sh_dst; cnt <= sh_cnt;
    end else if (!en && reg_we) begin
      if (reg_addr == 3'd0) src <= reg_wdata;
      if (reg_addr == 3'd1) dst <= reg_wdata;
      if (reg_addr == 3'd2) cnt <= reg_wdata;
    end else begin
      if (rd_done) begin
        src <= adv(src, sdir, step);
        cnt <= cnt_nx;
      end
      if (wr_done) dst <= adv(dst, ddir, step);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; en <= 1'b0; pend <= 1'b0; irq_q <= 1'b0;
      tc_q <= 1'b0; dreq_q <= 1'b0; dlatch <= '0;
    end else begin
      dreq_q <= dreq;
      tc_q   <= finish && pin_en;
      if (stop || finish) en <= 1'b0;
      else if (en_set)    en <= 1'b1;
      if (stop || finish)           pend <= 1'b0;
      else if (en && dreq && !dreq_q) pend <= 1'b1;
      if (finish)                        irq_q <= 1'b1;
      else if (ctrl_wr && reg_wdata[2])  irq_q <= 1'b0;
      if (rd_done) dlatch <= bus_rdata;
      if (stop) state <= S_IDLE;
      else case (state)
        S_IDLE:  if (en && pend) state <= S_RD;
        S_RD:    if (rd_done) state <= S_WR;
        S_WR:    if (wr_done) state <= finish ? S_IDLE : S_RD;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign bus_req   = (state != S_IDLE);
  assign bus_we    = (state == S_WR);
  assign bus_wide  = wide;
  assign bus_addr  = (state == S_WR) ? dst : src;
  assign bus_wdata = dlatch;
  assign tc_out    = tc_q;
  assign irq       = irq_q;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = src;
      3'd1:    reg_rdata = dst;
      3'd2:    reg_rdata = cnt;
      3'd3:    reg_rdata = AW'(mode);
      3'd4:    reg_rdata = AW'({irq_q, pend, en});
      default: reg_rdata = '0;
    endcase
  end

  p_wait_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_rdy && !stop) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  p_read_then_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_rdy && !stop) |=> (bus_req && bus_we));

  p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_rdy && !stop) |=> (cnt <= $past(cnt)));

  p_abort_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !irq_q) |=> (!bus_req && !en && !irq_q && !tc_q));

  p_tc_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |=> !tc_out);

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(ctrl_wr && reg_wdata[2])) |=> irq);

endmodule

// File: tb/tb_dma_engine.sv
module tb_dma_engine;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [23:0] reg_wdata = '0, reg_rdata;
  logic        dreq = 1'b0, tc_stop_n = 1'b1, tc_out, irq;
  logic        bus_req, bus_we, bus_wide, bus_rdy = 1'b0;
  logic [23:0] bus_addr;
  logic [15:0] bus_wdata, bus_rdata;

  int checks = 0, errors = 0;
  int tr_n = 0, tc_cnt = 0;
  bit rand_rdy = 1'b0;
  logic        tr_we   [0:255];
  logic [23:0] tr_addr [0:255];
  logic [15:0] tr_data [0:255];

  function automatic logic [15:0] memf(input logic [23:0] a);
    return (a[15:0] * 16'd3) ^ {a[23:16], 8'hA5};
  endfunction

  function automatic logic [23:0] adv(input logic [23:0] a, input int dir, input bit w, input int k);
    logic [23:0] s;
    s = 24'(k * (w ? 2 : 1));
    case (dir)
      0: return a + s;
      1: return a - s;
      default: return a;
    endcase
  endfunction

  assign bus_rdata = memf(bus_addr);

  dma_engine dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .dreq(dreq), .tc_stop_n(tc_stop_n), .tc_out(tc_out), .irq(irq),
    .bus_req(bus_req), .bus_we(bus_we), .bus_wide(bus_wide), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rdy(bus_rdy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    bus_rdy = rand_rdy ? (($urandom % 3) != 0) : 1'b1;
    if (bus_req && bus_rdy && tr_n < 256) begin
      tr_we[tr_n] = bus_we; tr_addr[tr_n] = bus_addr; tr_data[tr_n] = bus_wdata;
      tr_n = tr_n + 1;
    end
    if (tc_out) tc_cnt = tc_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [23:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output logic [23:0] v);
    reg_addr = a; #1; v = reg_rdata;
  endtask

  task automatic pulse_dreq();
    @(negedge clk); dreq = 1'b1;
    repeat (3) @(negedge clk);
    dreq = 1'b0;
  endtask

  task automatic setup(input logic [23:0] s, input logic [23:0] d, input logic [23:0] c,
                       input logic [5:0] m);
    wr_reg(0, s); wr_reg(1, d); wr_reg(2, c); wr_reg(3, 24'(m));
    tr_n = 0; tc_cnt = 0;
    wr_reg(4, 24'h000001);
  endtask

  task automatic wait_idle();
    logic [23:0] v;
    int t = 0;
    do begin
      @(negedge clk); rd_reg(4, v); t++;
    end while (v[0] && t < 4000);
    repeat (3) @(negedge clk);
  endtask

  task automatic verify(input logic [23:0] s, input logic [23:0] d, input int c, input int sd,
                        input int dd, input bit w, input bit pin);
    int units, bad_rd, bad_wr;
    logic [23:0] v;
    units = w ? (c + 1) / 2 : c;
    bad_rd = 0; bad_wr = 0;
    chk(tr_n == 2 * units, "R2 unit count", tr_n, 2 * units);
    for (int k = 0; k < units && 2 * k + 1 < tr_n; k++) begin
      if (tr_we[2*k] !== 1'b0 || tr_addr[2*k] !== adv(s, sd, w, k)) bad_rd++;
      if (tr_we[2*k+1] !== 1'b1 || tr_addr[2*k+1] !== adv(d, dd, w, k) ||
          tr_data[2*k+1] !== memf(adv(s, sd, w, k))) bad_wr++;
    end
    chk(bad_rd == 0, "R3 source address sequence", bad_rd, 0);
    chk(bad_wr == 0, "R2 destination address/data", bad_wr, 0);
    rd_reg(0, v); chk(v == adv(s, sd, w, units), "R3 final source", v, adv(s, sd, w, units));
    rd_reg(1, v); chk(v == adv(d, dd, w, units), "R3 final destination", v, adv(d, dd, w, units));
    rd_reg(2, v); chk(v == 0, "R4 final count", v, 0);
    rd_reg(4, v); chk(v[2:0] == 3'b100, "R5 status after finish", v[2:0], 3'b100);
    chk(tc_cnt == (pin ? 1 : 0), pin ? "R5 tc pulse" : "R12 tc suppressed", tc_cnt, pin ? 1 : 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [23:0] v;
    int n;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd_reg(4, v);
    chk(v == 0 && !bus_req && !tc_out && !irq, "R1 reset state", v, 0);

    wr_reg(0, 24'hABCDEF); rd_reg(0, v); chk(v == 24'hABCDEF, "R1 source readback", v, 24'hABCDEF);
    wr_reg(2, 24'h800001); rd_reg(2, v); chk(v == 24'h800001, "R1 count readback", v, 24'h800001);

    // forward/forward bytes, always ready
    setup(24'h001000, 24'h002000, 24'd5, 6'b100000);
    pulse_dreq(); wait_idle();
    verify(24'h001000, 24'h002000, 5, 0, 0, 1'b0, 1'b1);
    chk(irq == 1'b1, "R11 irq held", irq, 1);
    repeat (5) @(negedge clk);
    chk(irq == 1'b1, "R11 irq still held", irq, 1);
    wr_reg(4, 24'h000004);
    chk(irq == 1'b0, "R11 irq cleared", irq, 0);

    // R8: rerun from saved settings
    tr_n = 0; tc_cnt = 0;
    wr_reg(4, 24'h000001); pulse_dreq(); wait_idle();
    verify(24'h001000, 24'h002000, 5, 0, 0, 1'b0, 1'b1);
    rd_reg(0, v); chk(v == 24'h001005, "R8 rerun source end", v, 24'h001005);
    wr_reg(4, 24'h000004);

    // wide odd count, backward source, fixed destination, random ready
    rand_rdy = 1'b1;
    setup(24'h00FFF0, 24'h300000, 24'd5, 6'b110011);
    pulse_dreq(); wait_idle();
    verify(24'h00FFF0, 24'h300000, 5, 1, 2, 1'b1, 1'b1);
    wr_reg(4, 24'h000004);

    // random mix
    for (int i = 0; i < 8; i++) begin
      logic [23:0] s, d;
      int c, sd, dd;
      bit w;
      s = 24'($urandom); d = 24'($urandom);
      c = 1 + ($urandom % 14); sd = $urandom % 4; dd = $urandom % 4; w = 1'($urandom);
      setup(s, d, 24'(c), {1'b1, 2'(dd), 2'(sd), w});
      pulse_dreq(); wait_idle();
      verify(s, d, c, sd > 1 ? 2 : sd, dd > 1 ? 2 : dd, w, 1'b1);
      wr_reg(4, 24'h000004);
    end
    rand_rdy = 1'b0;

    // R12 and R7 ignore: pin inactive
    setup(24'h000100, 24'h000200, 24'd6, 6'b000001);
    pulse_dreq();
    tc_stop_n = 1'b0; @(negedge clk); tc_stop_n = 1'b1;
    wait_idle();
    verify(24'h000100, 24'h000200, 6, 0, 0, 1'b1, 1'b0);
    chk(irq == 1'b1, "R7 stop pin ignored when inactive", irq, 1);
    wr_reg(4, 24'h000004);

    // R6 stop by enable write
    setup(24'h010000, 24'h020000, 24'd40, 6'b100000);
    pulse_dreq();
    repeat (4) @(negedge clk);
    wr_reg(4, 24'h000000);
    repeat (2) @(negedge clk);
    n = tr_n;
    repeat (10) @(negedge clk);
    chk(tr_n == n && !bus_req, "R6 bus quiet after stop", tr_n, n);
    chk(n < 80, "R6 transfer cut short", n, 80);
    rd_reg(4, v);
    chk(v[2:0] == 3'b000 && tc_cnt == 0, "R6 no irq/tc after stop", v[2:0], 0);

    // R7 stop by pin
    setup(24'h010000, 24'h020000, 24'd40, 6'b100000);
    pulse_dreq();
    repeat (3) @(negedge clk);
    tc_stop_n = 1'b0; @(negedge clk); tc_stop_n = 1'b1;
    @(negedge clk);
    n = tr_n;
    repeat (10) @(negedge clk);
    chk(tr_n == n && !bus_req, "R7 bus quiet after pin stop", tr_n, n);
    rd_reg(4, v);
    chk(v[2:0] == 3'b000 && tc_cnt == 0, "R7 no irq/tc after pin stop", v[2:0], 0);

    // R9: level already high when enabled does not start
    @(negedge clk); dreq = 1'b1;
    setup(24'h000040, 24'h000080, 24'd2, 6'b100000);
    repeat (10) @(negedge clk);
    rd_reg(4, v);
    chk(tr_n == 0 && v[1] == 1'b0, "R9 held level ignored", tr_n, 0);
    dreq = 1'b0; @(negedge clk);
    pulse_dreq(); wait_idle();
    verify(24'h000040, 24'h000080, 2, 0, 0, 1'b0, 1'b1);
    wr_reg(4, 24'h000004);

    // R9: edge while disabled ignored
    tr_n = 0;
    pulse_dreq();
    wr_reg(4, 24'h000001);
    repeat (10) @(negedge clk);
    rd_reg(4, v);
    chk(tr_n == 0 && v[1] == 1'b0, "R9 edge while disabled ignored", tr_n, 0);
    wr_reg(4, 24'h000000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule